// File: doc/BRIEF.md
# Dual 32-bit Count-Up Timer

This peripheral holds two independent up-counters, a lower half and an upper half, each paired with its own period register. A shared enable word gives each half a 2-bit mode field: disabled, one-shot or periodic. A global control word picks the timer mode and releases each half from reset on its own. Only the unchained 32-bit mode (mode value 1) makes the counters advance. In periodic mode a half pulses its interrupt when its count reaches the period, then restarts from zero. In one-shot mode it pulses once, stops and clears its own mode field.

The lower counter also feeds a bank of compare registers. When the lower counter is active and its value equals any compare entry, a compare interrupt pulses. Because the counter wraps through zero when its period is all ones, matching follows that 32-bit wrap. Software reaches every register through a word-wide bus: byte address, write enable, write data and combinational read data.

Top module: `dual_up_timer`

## Requirements
- R1: After reset every register reads 0 and all three interrupt outputs are low. Any address outside the map below reads 0, and so does any address whose two low bits are not 00.
- R2: The register map uses these byte offsets: lower count 0x10, upper count 0x14, lower period 0x18, upper period 0x1C, enable word 0x20, global control 0x24, and compare entry i at 0x60+4*i for i = 0..7. Period and compare entries read back the full word written. The enable word keeps only bits 7:6 and 23:22. Global control keeps only bits 3:0. Writes to unmapped or misaligned addresses change nothing.
- R3: The lower half takes its mode from enable bits 7:6 and the upper half from bits 23:22. Value 2 (periodic) adds 1 to the count on each clock. In the cycle where the count equals the period, the next clock loads 0 and raises that half's interrupt for the following cycle only. Value 0 (and value 3) freezes the count and raises no interrupt.
- R4: Value 1 (one-shot) counts the same way as periodic. At the clock where the count equals the period, the half raises its interrupt for one cycle, holds its count, and its mode field reads 0 from then on.
- R5: Global control bit 0 releases the lower half and bit 1 releases the upper half. While its bit is 0, a half reads 0, ignores its mode field and its count writes, and raises no interrupt.
- R6: The counters advance only while global control bits 3:2 equal 1. Any other value freezes both counts and suppresses all interrupts.
- R7: With a period of all ones, the count steps from 0xFFFFFFFF to 0 and raises the period interrupt on that step.
- R8: A write to a released counter sets its count to the written value on that clock. The write wins over the increment, the reload and the period interrupt of that cycle.
- R9: The compare interrupt is high in the cycle after any cycle in which all of the following hold: the lower half is released, the mode is 1, the lower mode field is 1 or 2, and the lower count equals any compare entry. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_we | input | 1 | Write strobe, one word per clock |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data, combinational from bus_addr |
| irq_lo | output | 1 | Lower half period interrupt pulse |
| irq_hi | output | 1 | Upper half period interrupt pulse |
| irq_cmp | output | 1 | Compare-match interrupt pulse |

## Verification
The assertions check these rules on every cycle:
- A held lower half reads zero.
- A periodic hit reloads zero and raises an interrupt.
- A one-shot hit clears the mode field.
- A non-unchained mode freezes the count.
- A counter write lands exactly.
- A compare pulse appears only after an active cycle.

Some behaviour needs the bench's scenarios instead: the exact cycle-by-cycle counts across a sweep of periods and both modes on both halves, the wrap through all ones, which of the eight entries matched, and the read map. For these the bench runs an arithmetic model of the map and compares every cycle.

// File: rtl/dtim_pkg.sv
package dtim_pkg;

    // word indices (byte offset / 4) of the register map
    localparam int WA_CNT_LO   = 4;
    localparam int WA_CNT_HI   = 5;
    localparam int WA_PRD_LO   = 6;
    localparam int WA_PRD_HI   = 7;
    localparam int WA_ENABLE   = 8;
    localparam int WA_GLOBAL   = 9;
    localparam int WA_CMP_BASE = 24;

    // mode-field positions inside the enable word
    localparam int LO_EN_LSB = 6;
    localparam int HI_EN_LSB = 22;

    // global control fields
    localparam int GC_MODE_LSB = 2;
    localparam int GC_W        = 4;

    // mode-field encodings
    localparam logic [1:0] EN_OFF  = 2'd0;
    localparam logic [1:0] EN_ONCE = 2'd1;
    localparam logic [1:0] EN_LOOP = 2'd2;

    // timer mode that lets the counters run
    localparam logic [1:0] TM_SPLIT32 = 2'd1;

endpackage

// File: rtl/dtim_counter.sv
module dtim_counter import dtim_pkg::*; #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         run,
    input  logic [1:0]   mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         tick_irq,
    output logic         once_done
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    live;

    assign live = run && (mode == EN_ONCE || mode == EN_LOOP);

    always_comb begin
        st_d      = st_q;
        st_d.irq  = 1'b0;
        once_done = 1'b0;
        if (hold) begin
            st_d.cnt = '0;
        end else if (wr_en) begin
            st_d.cnt = wr_data;
        end else if (live) begin
            if (st_q.cnt == period) begin
                st_d.irq = 1'b1;
                if (mode == EN_LOOP) begin
                    st_d.cnt = '0;
                end else begin
                    once_done = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign tick_irq = st_q.irq;

endmodule

// File: rtl/dtim_cmp_bank.sv
module dtim_cmp_bank #(
    parameter int W     = 32,
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    input  logic [W-1:0]     count,
    input  logic             active,
    output logic             irq
);

    typedef struct packed {
        logic [N-1:0][W-1:0] ent;
        logic                irq;
    } bank_st_t;

    bank_st_t    st_d, st_q;
    logic [N-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_match
            assign hit[i] = (st_q.ent[i] == count);
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.irq = active && (|hit);
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.ent[rd_idx];
    assign irq     = st_q.irq;

endmodule

// File: rtl/dual_up_timer.sv
module dual_up_timer import dtim_pkg::*; #(
    parameter int W       = 32,
    parameter int ADDR_W  = 8,
    parameter int NUM_CMP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              irq_cmp
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
    localparam logic [WORD_W-1:0] A_CNT_LO = WORD_W'(WA_CNT_LO);
    localparam logic [WORD_W-1:0] A_CNT_HI = WORD_W'(WA_CNT_HI);
    localparam logic [WORD_W-1:0] A_PRD_LO = WORD_W'(WA_PRD_LO);
    localparam logic [WORD_W-1:0] A_PRD_HI = WORD_W'(WA_PRD_HI);
    localparam logic [WORD_W-1:0] A_ENABLE = WORD_W'(WA_ENABLE);
    localparam logic [WORD_W-1:0] A_GLOBAL = WORD_W'(WA_GLOBAL);
    localparam logic [WORD_W-1:0] A_CMP    = WORD_W'(WA_CMP_BASE);

    typedef struct packed {
        logic [1:0][W-1:0] prd;
        logic [1:0][1:0]   en;
        logic [GC_W-1:0]   gcr;
    } regs_t;

    regs_t r_d, r_q;

    logic [WORD_W-1:0] word, cmp_off;
    logic              aligned, in_cmp, run, cmp_active;
    logic [IDX_W-1:0]  cmp_idx;
    logic [1:0]        rel, wr_cnt, done, irq_per;
    logic [1:0][W-1:0] cnt;
    logic [W-1:0]      cmp_rd;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign cmp_off = word - A_CMP;
    assign in_cmp  = aligned && (word >= A_CMP) && (cmp_off < WORD_W'(NUM_CMP));
    assign cmp_idx = cmp_off[IDX_W-1:0];
    assign run     = (r_q.gcr[GC_MODE_LSB+:2] == TM_SPLIT32);

    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            assign rel[h]    = r_q.gcr[h];
            assign wr_cnt[h] = bus_we && aligned && (word == ((h == 0) ? A_CNT_LO : A_CNT_HI));

            dtim_counter #(.W(W)) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .hold      (!rel[h]),
                .run       (run),
                .mode      (r_q.en[h]),
                .wr_en     (wr_cnt[h]),
                .wr_data   (bus_wdata),
                .period    (r_q.prd[h]),
                .count     (cnt[h]),
                .tick_irq  (irq_per[h]),
                .once_done (done[h])
            );
        end
    endgenerate

    assign cmp_active = rel[0] && run && (r_q.en[0] == EN_ONCE || r_q.en[0] == EN_LOOP);

    dtim_cmp_bank #(.W(W), .N(NUM_CMP)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && in_cmp),
        .wr_idx  (cmp_idx),
        .wr_data (bus_wdata),
        .rd_idx  (cmp_idx),
        .rd_data (cmp_rd),
        .count   (cnt[0]),
        .active  (cmp_active),
        .irq     (irq_cmp)
    );

    // next register state: one-shot completion clears the field, a bus write wins
    always_comb begin
        r_d = r_q;
        for (int k = 0; k < 2; k++) begin
            if (done[k]) begin
                r_d.en[k] = EN_OFF;
            end
        end
        if (bus_we && aligned) begin
            case (word)
                A_PRD_LO: r_d.prd[0] = bus_wdata;
                A_PRD_HI: r_d.prd[1] = bus_wdata;
                A_ENABLE: begin
                    r_d.en[0] = bus_wdata[LO_EN_LSB+:2];
                    r_d.en[1] = bus_wdata[HI_EN_LSB+:2];
                end
                A_GLOBAL: r_d.gcr = bus_wdata[GC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (word)
                A_CNT_LO: bus_rdata = cnt[0];
                A_CNT_HI: bus_rdata = cnt[1];
                A_PRD_LO: bus_rdata = r_q.prd[0];
                A_PRD_HI: bus_rdata = r_q.prd[1];
                A_ENABLE: begin
                    bus_rdata[LO_EN_LSB+:2] = r_q.en[0];
                    bus_rdata[HI_EN_LSB+:2] = r_q.en[1];
                end
                A_GLOBAL: bus_rdata[GC_W-1:0] = r_q.gcr;
                default:  if (in_cmp) bus_rdata = cmp_rd;
            endcase
        end
    end

    assign irq_lo = irq_per[0];
    assign irq_hi = irq_per[1];

endmodule

// File: rtl/dtim_checker.sv
module dtim_checker #(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [3:0]        gcr,
    input logic [1:0]        en_lo,
    input logic [W-1:0]      cnt_lo,
    input logic [W-1:0]      prd_lo,
    input logic              irq_lo,
    input logic              irq_cmp
);

    logic wr_cnt_lo, wr_en_word, run, hit_lo;

    assign wr_cnt_lo  = bus_we && (bus_addr == ADDR_W'(8'h10));
    assign wr_en_word = bus_we && (bus_addr == ADDR_W'(8'h20));
    assign run        = gcr[0] && (gcr[3:2] == 2'd1);
    assign hit_lo     = run && !wr_cnt_lo && (cnt_lo == prd_lo);

    // R5
    lo_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gcr[0] |=> (cnt_lo == '0));

    // R3
    loop_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lo && en_lo == 2'd2) |=> (cnt_lo == '0 && irq_lo));

    // R4
    once_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_lo && en_lo == 2'd1 && !wr_en_word) |=> (en_lo == 2'd0 && irq_lo));

    // R6
    mode_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gcr[0] && gcr[3:2] != 2'd1 && !wr_cnt_lo) |=> (cnt_lo == $past(cnt_lo) && !irq_lo));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gcr[0] && wr_cnt_lo) |=> (cnt_lo == $past(bus_wdata) && !irq_lo));

    // R9
    cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp |-> $past(run && (en_lo == 2'd1 || en_lo == 2'd2)));

endmodule

bind dual_up_timer dtim_checker #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .gcr       (r_q.gcr),
    .en_lo     (r_q.en[0]),
    .cnt_lo    (cnt[0]),
    .prd_lo    (r_q.prd[0]),
    .irq_lo    (irq_lo),
    .irq_cmp   (irq_cmp)
);

// File: tb/dual_up_timer_test.sv
`timescale 1ns/100ps
module dual_up_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi, irq_cmp;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dual_up_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
    );

    // arithmetic model of the register map
    logic [31:0] m_cnt [2];
    logic [31:0] m_prd [2];
    logic [1:0]  m_en  [2];
    logic [31:0] m_cmp [8];
    logic [3:0]  m_gcr;
    logic        m_irq [2];
    logic        m_cirq;

    task automatic model_reset();
        for (int h = 0; h < 2; h++) begin
            m_cnt[h] = '0; m_prd[h] = '0; m_en[h] = '0; m_irq[h] = 1'b0;
        end
        for (int i = 0; i < 8; i++) m_cmp[i] = '0;
        m_gcr = '0; m_cirq = 1'b0;
    endtask

    task automatic model_edge(input bit we, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] nc [2];
        logic [1:0]  ne [2];
        bit run, act, al;
        int w;
        al  = (a[1:0] == 2'b00);
        w   = int'(a[7:2]);
        run = (m_gcr[3:2] == 2'd1);
        act = m_gcr[0] && run && (m_en[0] == 2'd1 || m_en[0] == 2'd2);
        m_cirq = 1'b0;
        if (act) for (int i = 0; i < 8; i++) if (m_cnt[0] == m_cmp[i]) m_cirq = 1'b1;
        for (int h = 0; h < 2; h++) begin
            nc[h] = m_cnt[h]; ne[h] = m_en[h]; m_irq[h] = 1'b0;
            if (!m_gcr[h]) nc[h] = '0;
            else if (we && al && w == 4 + h) nc[h] = d;
            else if (run && (m_en[h] == 2'd1 || m_en[h] == 2'd2)) begin
                if (m_cnt[h] == m_prd[h]) begin
                    m_irq[h] = 1'b1;
                    if (m_en[h] == 2'd2) nc[h] = '0;
                    else ne[h] = 2'd0;
                end else nc[h] = m_cnt[h] + 1;
            end
        end
        if (we && al) begin
            if (w == 6) m_prd[0] = d;
            if (w == 7) m_prd[1] = d;
            if (w == 8) begin ne[0] = d[7:6]; ne[1] = d[23:22]; end
            if (w == 9) m_gcr = d[3:0];
            if (w >= 24 && w < 32) m_cmp[w-24] = d;
        end
        for (int h = 0; h < 2; h++) begin m_cnt[h] = nc[h]; m_en[h] = ne[h]; end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock; caller sits at a negedge, returns at the next negedge
    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_edge(we, a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        rd({tag, " lo count"}, 8'h10, m_cnt[0]);
        rd({tag, " hi count"}, 8'h14, m_cnt[1]);
        rd({tag, " enable word"}, 8'h20, {8'h0, m_en[1], 14'h0, m_en[0], 6'h0});
        chk({tag, " irq_lo"}, {31'h0, irq_lo}, {31'h0, m_irq[0]});
        chk({tag, " irq_hi"}, {31'h0, irq_hi}, {31'h0, m_irq[1]});
        chk({tag, " irq_cmp"}, {31'h0, irq_cmp}, {31'h0, m_cirq});
    endtask

    task automatic run_cycles(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            cyc(1'b0, 8'h00, '0);
            check_all(tag);
        end
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and unmapped reads
        for (int a = 0; a < 256; a += 4) rd("R1 reset read", 8'(a), 32'h0);
        rd("R1 misaligned read", 8'h11, 32'h0);
        chk("R1 irq after reset", {29'h0, irq_lo, irq_hi, irq_cmp}, 32'h0);

        // R2: readback of writable fields and the compare bank
        cyc(1, 8'h18, 32'hA5A5_1234);
        cyc(1, 8'h1C, 32'h5A5A_4321);
        for (int i = 0; i < 8; i++) cyc(1, 8'(8'h60 + 4 * i), 32'h0101_0101 * i + 32'h100);
        cyc(1, 8'h20, 32'hFFFF_FFFF);
        cyc(1, 8'h24, 32'hFFFF_FFF0);
        cyc(1, 8'h28, 32'hDEAD_BEEF);
        cyc(1, 8'h19, 32'h1111_1111);
        rd("R2 lo period", 8'h18, 32'hA5A5_1234);
        rd("R2 hi period", 8'h1C, 32'h5A5A_4321);
        for (int i = 0; i < 8; i++) rd("R2 compare entry", 8'(8'h60 + 4 * i), 32'h0101_0101 * i + 32'h100);
        rd("R2 enable word bits", 8'h20, 32'h00C0_00C0);
        rd("R2 global bits", 8'h24, 32'h0);
        rd("R2 unmapped write", 8'h28, 32'h0);
        cyc(1, 8'h24, 32'hFFFF_FFFF);
        rd("R2 global readback", 8'h24, 32'h0000_000F);
        cyc(1, 8'h20, 32'h0);
        cyc(1, 8'h24, 32'h0);

        // R3 / R4: sweep of halves, modes and small periods
        for (int h = 0; h < 2; h++) begin
            for (int md = 1; md <= 2; md++) begin
                for (int p = 0; p < 6; p++) begin
                    cyc(1, 8'h20, 32'h0);
                    cyc(1, 8'h24, 32'h7);
                    cyc(1, 8'(8'h10 + 4 * h), 32'h0);
                    cyc(1, 8'(8'h18 + 4 * h), 32'(p));
                    cyc(1, 8'h20, (h == 0) ? 32'(md) << 6 : 32'(md) << 22);
                    check_all((md == 1) ? "R4 one-shot sweep" : "R3 periodic sweep");
                    run_cycles((md == 1) ? "R4 one-shot sweep" : "R3 periodic sweep", 10);
                end
            end
        end

        // R3: disabled field and reserved value 3 freeze the count
        cyc(1, 8'h20, 32'h0);
        cyc(1, 8'h10, 32'd9);
        run_cycles("R3 disabled hold", 4);
        cyc(1, 8'h20, 32'h00C0_00C0);
        run_cycles("R3 reserved value hold", 4);

        // R5: lower held, upper released and running
        cyc(1, 8'h18, 32'd3);
        cyc(1, 8'h1C, 32'd3);
        cyc(1, 8'h24, 32'h6);
        cyc(1, 8'h20, 32'h0080_0080);
        cyc(1, 8'h10, 32'h55);
        check_all("R5 held lower");
        run_cycles("R5 held lower", 8);
        cyc(1, 8'h24, 32'h5);
        run_cycles("R5 held upper", 6);

        // R6: modes other than 1 freeze both counters
        cyc(1, 8'h24, 32'h3);
        cyc(1, 8'h10, 32'd20);
        cyc(1, 8'h14, 32'd21);
        run_cycles("R6 mode 0 freeze", 5);
        cyc(1, 8'h24, 32'hB);
        run_cycles("R6 mode 2 freeze", 5);

        // R7: all-ones period wraps through zero, compare follows the wrap
        cyc(1, 8'h24, 32'h7);
        cyc(1, 8'h60, 32'h1);
        cyc(1, 8'h18, 32'hFFFF_FFFF);
        cyc(1, 8'h10, 32'hFFFF_FFFD);
        cyc(1, 8'h20, 32'h0000_0080);
        run_cycles("R7 wrap", 6);

        // R8: a counter write beats the increment
        cyc(1, 8'h10, 32'd100);
        check_all("R8 write priority");
        run_cycles("R8 after write", 3);
        cyc(1, 8'h18, 32'd50);
        cyc(1, 8'h10, 32'd50);
        check_all("R8 write at period");

        // R9: each compare entry in turn against a running lower counter
        for (int i = 0; i < 8; i++) cyc(1, 8'(8'h60 + 4 * i), 32'(3 + 3 * i));
        cyc(1, 8'h18, 32'd40);
        cyc(1, 8'h10, 32'd0);
        run_cycles("R9 compare sweep", 45);
        cyc(1, 8'h20, 32'h0);
        cyc(1, 8'h10, 32'd3);
        run_cycles("R9 compare while disabled", 4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule